// File: doc/BRIEF.md
# I2C Slave Receiver with 7-bit and 10-bit Address Matching

This block is the receive front end of an I2C target that runs entirely in a system clock domain. SCL and SDA are oversampled through flop synchronizers. Start, Repeated Start and Stop conditions are recognised from the sampled lines, and bytes are shifted in most significant bit first. Each address byte is matched against an address register that the host can write. The block pulls SDA low to acknowledge a byte and pulls SCL low to stretch the bus while the host must reload the address register.

In 7-bit mode one address byte is enough. In 10-bit mode the match takes two passes. The host first loads the high pattern `11110 A9 A8 x`. When that byte matches, the bus is held until the host writes the low address byte. When the low byte matches, the bus is held again until the host restores the high pattern. After a full 10-bit match, a Repeated Start followed by the high pattern with the read bit set is accepted without a second pass.

The host side is a small set of registers: a receive buffer, buffer-full, overflow, update-address and interrupt flags, and the captured read/write bit. Every received byte, address bytes included, goes through a gate. The byte is stored and acknowledged only when neither the buffer-full flag nor the overflow flag is set.

Top module: `i2c10_slave`

## Requirements
- R1: A Start or Repeated Start (SDA falling while SCL is high) begins a new address phase with the bit count cleared. A Stop (SDA rising while SCL is high) returns the block to idle. Data bits are taken on SCL rising edges, most significant bit first.
- R2: In 7-bit mode (`mode10_i`=0), bits 7:1 of the first byte after a Start are compared with bits 7:1 of the address register on the eighth SCL falling edge. On a match, SDA is held low through the ninth clock and `rw_o` takes bit 0 of the byte.
- R3: An address byte that does not match gets no acknowledge, sets no flag and causes no clock stretch. All further bytes are ignored until the next Start.
- R4: In 10-bit mode, a first byte matches when bits 7:3 are 11110, bits 7:1 equal the address register bits 7:1, and bit 0 is 0. It is acknowledged, sets `ua_o` and `rw_o`=0, and SCL is held low from the ninth falling edge until the host writes the address register.
- R5: In 10-bit mode, the byte that follows a matched high byte must equal all 8 bits of the address register. On a match it is acknowledged, sets `ua_o` and stretches SCL in the same way. Later bytes are received as data.
- R6: After a full 10-bit match and before any Stop, a Repeated Start followed by the high pattern with bit 0 = 1 is acknowledged and sets `rw_o`=1. It does not set `ua_o` or stretch SCL. Without a prior 10-bit match, the same byte is not acknowledged.
- R7: A matched or data byte received while buffer-full and overflow are both 0 is copied into `buf_q`, sets `full_o` and is acknowledged. While `full_o` is 1, `buf_q` never changes.
- R8: A matched or data byte received while `full_o` or `ovf_o` is 1 is not acknowledged and leaves `buf_q` unchanged, and the block goes idle. `ovf_o` is set if `full_o` was 1 and `ovf_o` was 0.
- R9: `irq_o` is set on the ninth SCL falling edge of every byte that matched or was data, whether or not it was acknowledged. It is cleared by `irq_clr`.
- R10: `buf_rd` clears `full_o` and `ovf_clr` clears `ovf_o`. A write of the address register clears `ua_o` and releases SCL in the next cycle.
- R11: After reset all flags, `buf_q` and `rw_o` are 0, neither line is driven, and the address register holds `ADDR_RST` (default 8'h84).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| mode10_i | input | 1 | 1 selects 10-bit address matching |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | BW | Address register write data |
| buf_rd | input | 1 | Host read of the receive buffer, clears buffer-full |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| buf_q | output | BW | Receive buffer |
| full_o | output | 1 | Buffer-full flag |
| ovf_o | output | 1 | Overflow flag |
| ua_o | output | 1 | Address register must be rewritten |
| irq_o | output | 1 | Interrupt flag |
| rw_o | output | 1 | Read/write bit of the last accepted address |

## Verification
A 7-bit write with the reset address, followed by data bytes, separates the ACK/store path from the R/W capture. Leaving the buffer unread, and then leaving only the overflow set, separates the two gate conditions and shows that the interrupt still arrives on a refused byte. Wrong 7-bit addresses, a wrong low byte, a wrong A9/A8 pattern and a read-flavoured high byte with no prior match tell a true match from near misses. The full two-pass 10-bit sequence with a Repeated Start read shows that stretching happens only while the address must be reloaded and that release follows the host write.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // link layer state of the receiver
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AHI,   // first byte after (repeated) start
    ST_ALO,   // second byte of a 10-bit address
    ST_DATA,  // addressed write, bytes are data
    ST_READ   // addressed read, receive side parked
  } lnk_st_t;

  // prefix that marks a 10-bit high address byte
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  // SDA may only move during SCL high to signal a condition
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_s,
  input  logic          mode10,
  input  logic [BW-1:0] addr,
  input  logic          full,
  input  logic          ovf,
  output logic [BW-1:0] shreg,
  output logic          ev_byte,
  output logic          ev_ok,
  output logic          ev_ua,
  output logic          ev_rw,
  output logic          ev_ninth,
  output logic          sda_oe
);
  localparam int CW = $clog2(BW + 2);
  localparam logic [CW-1:0] LAST = CW'(BW);
  localparam logic [CW-1:0] ACKB = CW'(BW + 1);

  lnk_st_t st, nxt;
  logic [CW-1:0] cnt;
  logic m10, pend;
  logic hit, gate, want_ua, upd_rw, set10;
  logic rx_on, at8, at9;

  assign rx_on = (st == ST_AHI) || (st == ST_ALO) || (st == ST_DATA);
  assign at8   = scl_fall && (cnt == LAST);
  assign at9   = scl_fall && (cnt == ACKB);

  // decision on the completed byte
  always_comb begin
    hit     = 1'b0;
    nxt     = ST_IDLE;
    want_ua = 1'b0;
    upd_rw  = 1'b0;
    set10   = 1'b0;
    unique case (st)
      ST_AHI: begin
        if (!mode10) begin
          hit    = (shreg[BW-1:1] == addr[BW-1:1]);
          nxt    = shreg[0] ? ST_READ : ST_DATA;
          upd_rw = 1'b1;
        end else if (shreg[BW-1 -: 5] == TEN_BIT_TAG &&
                     shreg[BW-1:1] == addr[BW-1:1]) begin
          if (!shreg[0]) begin
            hit     = 1'b1;
            nxt     = ST_ALO;
            want_ua = 1'b1;
            upd_rw  = 1'b1;
          end else if (m10) begin
            hit    = 1'b1;
            nxt    = ST_READ;
            upd_rw = 1'b1;
          end
        end
      end
      ST_ALO: begin
        hit     = (shreg == addr);
        nxt     = ST_DATA;
        want_ua = 1'b1;
        set10   = 1'b1;
      end
      ST_DATA: begin
        hit = 1'b1;
        nxt = ST_DATA;
      end
      default: ;
    endcase
    gate = hit && !full && !ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      m10      <= 1'b0;
      pend     <= 1'b0;
      sda_oe   <= 1'b0;
      ev_byte  <= 1'b0;
      ev_ok    <= 1'b0;
      ev_ua    <= 1'b0;
      ev_rw    <= 1'b0;
      ev_ninth <= 1'b0;
    end else begin
      ev_byte  <= 1'b0;
      ev_ok    <= 1'b0;
      ev_ua    <= 1'b0;
      ev_rw    <= 1'b0;
      ev_ninth <= 1'b0;
      if (start_ev) begin
        st     <= ST_AHI;
        cnt    <= '0;
        pend   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        pend   <= 1'b0;
        m10    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise && rx_on && cnt < LAST) begin
          shreg <= {shreg[BW-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end
        if (at8) begin
          cnt     <= ACKB;
          pend    <= hit;
          ev_byte <= hit;
          ev_ok   <= gate;
          ev_ua   <= gate && want_ua;
          ev_rw   <= gate && upd_rw;
          sda_oe  <= gate;
          if (gate) begin
            st <= nxt;
            if (set10) m10 <= 1'b1;
          end else begin
            st  <= ST_IDLE;
            m10 <= 1'b0;
          end
        end
        if (at9) begin
          cnt      <= '0;
          sda_oe   <= 1'b0;
          ev_ninth <= pend;
          pend     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave #(
  parameter int          BW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [BW-1:0] ADDR_RST  = 8'h84
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          mode10_i,
  input  logic          addr_we,
  input  logic [BW-1:0] addr_wdata,
  input  logic          buf_rd,
  input  logic          irq_clr,
  input  logic          ovf_clr,
  output logic [BW-1:0] buf_q,
  output logic          full_o,
  output logic          ovf_o,
  output logic          ua_o,
  output logic          irq_o,
  output logic          rw_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic [BW-1:0] addr, shreg;
  logic ev_byte, ev_ok, ev_ua, ev_rw, ev_ninth;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (scl_s),
    .sda      (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cs_engine #(.BW(BW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (sda_s),
    .mode10   (mode10_i),
    .addr     (addr),
    .full     (full_o),
    .ovf      (ovf_o),
    .shreg    (shreg),
    .ev_byte  (ev_byte),
    .ev_ok    (ev_ok),
    .ev_ua    (ev_ua),
    .ev_rw    (ev_rw),
    .ev_ninth (ev_ninth),
    .sda_oe   (sda_oe)
  );

  // host-visible registers; hardware sets win over host clears
  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= ADDR_RST;
      buf_q  <= '0;
      full_o <= 1'b0;
      ovf_o  <= 1'b0;
      ua_o   <= 1'b0;
      irq_o  <= 1'b0;
      rw_o   <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      if (buf_rd)  full_o <= 1'b0;
      if (ovf_clr) ovf_o  <= 1'b0;
      if (irq_clr) irq_o  <= 1'b0;
      if (addr_we) begin
        addr   <= addr_wdata;
        ua_o   <= 1'b0;
        scl_oe <= 1'b0;
      end
      if (ev_byte) begin
        if (ev_ok) begin
          buf_q  <= shreg;
          full_o <= 1'b1;
        end else if (full_o && !ovf_o) begin
          ovf_o <= 1'b1;
        end
      end
      if (ev_ua)    ua_o  <= 1'b1;
      if (ev_rw)    rw_o  <= shreg[0];
      if (ev_ninth) irq_o <= 1'b1;
      if (ev_ninth && ua_o && !addr_we) scl_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          addr_we,
  input logic          full_o,
  input logic          ovf_o,
  input logic          ua_o,
  input logic          irq_o,
  input logic [BW-1:0] buf_q
);
  // R8
  ovf_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(full_o));

  // R7
  buf_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(full_o) |-> $stable(buf_q));

  // R4
  hold_needs_ua_chk: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> ua_o);

  // R10
  release_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(addr_we) |-> !scl_oe);

  // R9
  irq_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !scl_i);

  // R2
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c10_slave i2cs_chk #(.BW(BW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .scl_i   (scl_i),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .addr_we (addr_we),
  .full_o  (full_o),
  .ovf_o   (ovf_o),
  .ua_o    (ua_o),
  .irq_o   (irq_o),
  .buf_q   (buf_q)
);

// File: tb/i2c10_slave_test.sv
module i2c10_slave_test;
  localparam int SETTLE = 6;
  localparam int Q      = 8;
  localparam int WDOG   = 150000;
  localparam int OP_RD = 0, OP_IRQ = 1, OP_OVF = 2, OP_ADR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic scl_ln, sda_ln;
  logic mode10 = 1'b0, addr_we = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] buf_q;
  logic full_o, ovf_o, ua_o, irq_o, rw_o;

  assign scl_ln = scl_m & ~scl_oe;
  assign sda_ln = sda_m & ~sda_oe;

  i2c10_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mode10_i(mode10),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .buf_rd(buf_rd),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .buf_q(buf_q),
    .full_o(full_o), .ovf_o(ovf_o), .ua_o(ua_o), .irq_o(irq_o), .rw_o(rw_o)
  );

  // behavioural model of the host-visible state
  int   m_st = 0;  // 0 idle, 1 addr hi, 2 addr lo, 3 data, 4 read
  bit   m10 = 0, m_pend = 0, m_mode10 = 0;
  logic [7:0] m_buf = 8'h00, m_addr = 8'h84;
  bit   m_full = 0, m_ovf = 0, m_ua = 0, m_irq = 0, m_rw = 0, m_hold = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit chk_en = 0, done = 0;
  string cur_req = "R11";

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", cyc, WDOG);
      finish_up();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en && !rst) begin
      n_chk++;
      if (buf_q !== m_buf || full_o !== m_full || ovf_o !== m_ovf || ua_o !== m_ua ||
          irq_o !== m_irq || rw_o !== m_rw || scl_oe !== m_hold) begin
        n_bad++;
        $display("FAIL %s t=%0t act buf=%h full=%b ovf=%b ua=%b irq=%b rw=%b hold=%b exp buf=%h full=%b ovf=%b ua=%b irq=%b rw=%b hold=%b",
                 cur_req, $time, buf_q, full_o, ovf_o, ua_o, irq_o, rw_o, scl_oe,
                 m_buf, m_full, m_ovf, m_ua, m_irq, m_rw, m_hold);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic d);
    @(negedge clk);
    scl_m  = c;
    sda_m  = d;
    chk_en = 0;
  endtask

  task automatic hold_on();
    repeat (SETTLE) @(negedge clk);
    chk_en = 1;
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_byte8(input logic [7:0] b);
    bit hit, ua_n, rw_n, s10;
    int nx;
    hit = 0; ua_n = 0; rw_n = 0; s10 = 0; nx = 0;
    if (m_st == 0 || m_st == 4) begin
      m_pend = 0;
      return;
    end
    if (m_st == 1) begin
      if (!m_mode10) begin
        hit = (b[7:1] == m_addr[7:1]); nx = b[0] ? 4 : 3; rw_n = 1;
      end else if (b[7:3] == 5'b11110 && b[7:1] == m_addr[7:1]) begin
        if (!b[0]) begin hit = 1; nx = 2; ua_n = 1; rw_n = 1; end
        else if (m10) begin hit = 1; nx = 4; rw_n = 1; end
      end
    end else if (m_st == 2) begin
      hit = (b == m_addr); nx = 3; ua_n = 1; s10 = 1;
    end else begin
      hit = 1; nx = 3;
    end
    m_pend = hit;
    if (hit && !m_full && !m_ovf) begin
      m_buf = b; m_full = 1;
      if (ua_n) m_ua = 1;
      if (rw_n) m_rw = b[0];
      if (s10) m10 = 1;
      m_st = nx;
    end else begin
      if (hit && m_full && !m_ovf) m_ovf = 1;
      m_st = 0; m10 = 0;
    end
  endtask

  task automatic do_start();
    bus(0, 1); hold_on();
    bus(1, 1); hold_on();
    bus(1, 0); m_st = 1; m_pend = 0; hold_on();
    bus(0, 0); hold_on();
  endtask

  task automatic do_stop();
    bus(0, 0); hold_on();
    bus(1, 0); hold_on();
    bus(1, 1); m_st = 0; m10 = 0; m_pend = 0; hold_on();
  endtask

  task automatic xbyte(input logic [7:0] b, input bit exp_ack, input string req);
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      bus(0, b[i]); hold_on();
      bus(1, b[i]); hold_on();
    end
    bus(0, 1); m_byte8(b); hold_on();
    bus(1, 1); hold_on();
    check(sda_ln == !exp_ack, req, $sformatf("SDA in ack slot for byte %h", b), sda_ln, !exp_ack);
    bus(0, 1);
    if (m_pend) begin
      m_irq = 1;
      if (m_ua) m_hold = 1;
    end
    m_pend = 0;
    hold_on();
  endtask

  task automatic host(input int op, input logic [7:0] d);
    @(negedge clk);
    chk_en = 0;
    case (op)
      OP_RD:  begin buf_rd  = 1; m_full = 0; end
      OP_IRQ: begin irq_clr = 1; m_irq  = 0; end
      OP_OVF: begin ovf_clr = 1; m_ovf  = 0; end
      default: begin addr_we = 1; addr_wdata = d; m_addr = d; m_ua = 0; m_hold = 0; end
    endcase
    @(negedge clk);
    buf_rd = 0; irq_clr = 0; ovf_clr = 0; addr_we = 0;
    hold_on();
  endtask

  task automatic ack_host();
    host(OP_RD, 8'h00);
    host(OP_IRQ, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(full_o == 0 && ovf_o == 0 && ua_o == 0 && irq_o == 0, "R11", "flags after reset", {full_o, ovf_o, ua_o, irq_o}, 0);
    check(buf_q == 8'h00 && rw_o == 0, "R11", "buffer and rw after reset", buf_q, 0);
    check(scl_oe == 0 && sda_oe == 0, "R11", "lines released after reset", {scl_oe, sda_oe}, 0);
    chk_en = 1;

    // R1 R2 R7: 7-bit write to reset address, then data
    do_start();
    xbyte(8'h84, 1, "R2");
    check(buf_q == 8'h84 && rw_o == 0, "R1", "address byte shifted MSB first", buf_q, 8'h84);
    check(irq_o == 1, "R9", "irq after ninth fall", irq_o, 1);
    ack_host();
    check(irq_o == 0 && full_o == 0, "R10", "host clears irq and full", {irq_o, full_o}, 0);
    xbyte(8'h5A, 1, "R7");
    ack_host();
    // R8: buffer left full, next byte refused and overflow set
    xbyte(8'h11, 1, "R7");
    xbyte(8'h22, 0, "R8");
    check(buf_q == 8'h11 && ovf_o == 1 && irq_o == 1, "R8", "refused byte keeps buffer, sets ovf and irq", buf_q, 8'h11);
    xbyte(8'h33, 0, "R3");
    do_stop();
    host(OP_RD, 8'h00);
    host(OP_IRQ, 8'h00);
    // R8: overflow alone also refuses the address byte
    do_start();
    xbyte(8'h84, 0, "R8");
    check(full_o == 0 && ovf_o == 1 && irq_o == 1, "R8", "ovf alone gates the byte", {full_o, ovf_o, irq_o}, 3'b011);
    do_stop();
    host(OP_OVF, 8'h00);
    host(OP_IRQ, 8'h00);
    check(ovf_o == 0, "R10", "ovf_clr clears overflow", ovf_o, 0);

    // R3: wrong 7-bit address
    do_start();
    xbyte(8'h86, 0, "R3");
    xbyte(8'hFF, 0, "R3");
    check(irq_o == 0 && full_o == 0 && scl_oe == 0, "R3", "mismatch leaves no trace", {irq_o, full_o, scl_oe}, 0);
    do_stop();

    // R2: 7-bit read captures rw
    do_start();
    xbyte(8'h85, 1, "R2");
    check(rw_o == 1, "R2", "rw from bit 0", rw_o, 1);
    do_stop();
    ack_host();

    // R4 R5 R6: full 10-bit sequence
    @(negedge clk); mode10 = 1; m_mode10 = 1;
    host(OP_ADR, 8'hF2);
    do_start();
    xbyte(8'hF2, 1, "R4");
    check(ua_o == 1 && scl_oe == 1 && rw_o == 0, "R4", "ua set and SCL held after high byte", {ua_o, scl_oe, rw_o}, 3'b110);
    ack_host();
    host(OP_ADR, 8'h3C);
    check(scl_oe == 0 && ua_o == 0, "R10", "address write releases SCL", {scl_oe, ua_o}, 0);
    xbyte(8'h3C, 1, "R5");
    check(ua_o == 1 && scl_oe == 1 && buf_q == 8'h3C, "R5", "low byte match holds SCL", {ua_o, scl_oe}, 3);
    ack_host();
    host(OP_ADR, 8'hF2);
    xbyte(8'h99, 1, "R5");
    ack_host();
    cur_req = "R1";
    do_start();
    xbyte(8'hF3, 1, "R6");
    check(rw_o == 1 && ua_o == 0 && scl_oe == 0, "R6", "read after repeated start", {rw_o, ua_o, scl_oe}, 4);
    do_stop();
    ack_host();

    // R6: read pattern without prior 10-bit match
    do_start();
    xbyte(8'hF3, 0, "R6");
    do_stop();

    // R5: wrong low byte
    do_start();
    xbyte(8'hF2, 1, "R4");
    ack_host();
    host(OP_ADR, 8'h3C);
    xbyte(8'h3D, 0, "R5");
    check(irq_o == 0 && scl_oe == 0, "R5", "low byte mismatch, no irq no stretch", {irq_o, scl_oe}, 0);
    do_stop();
    ack_host();

    // R4: wrong A9/A8 bits
    host(OP_ADR, 8'hF2);
    do_start();
    xbyte(8'hF6, 0, "R4");
    do_stop();

    repeat (20) @(negedge clk);
    finish_up();
  end
endmodule